// File: doc/BRIEF.md
# Scalar Floating-Point Compare Flag Unit

This unit compares two scalar IEEE-754 values and reduces the outcome to a three-bit status code held in a small flag register. The code has a zero bit, a parity bit and a carry bit. Three further status bits (overflow, sign, auxiliary) are always written as zero. Each operand arrives on a 128-bit bus. A precision select picks the low 32 bits of each bus (single precision) or the low 64 bits (double precision). A mode input chooses between a relaxed compare, where only signalling NaNs are invalid, and a strict compare, where every NaN is invalid.

Each compare also reports whether an invalid-operation or denormal-operand condition was raised. Two mask bits decide whether each condition is only reported, or whether it traps. When a trap fires, the flag register keeps its previous contents and only the trap output is asserted. Results appear one cycle after the input strobe, together with an output strobe. Between compares, the flags hold their value.

Top module: `fp_cmp_flags`

## Requirements
- R1: If either selected operand is a NaN, quiet or signalling, and no trap fires, the flags become {zf,pf,cf} = 3'b111. A NaN has an all-ones exponent and a nonzero fraction.
- R2: If operand A is greater than operand B, the flags become 3'b000. Infinities order normally, so -2.0 is greater than -infinity.
- R3: If operand A is less than operand B, the flags become 3'b001.
- R4: If the operands are equal, the flags become 3'b100. Positive zero and negative zero compare as equal.
- R5: The of, sf and af outputs are 0 after every compare.
- R6: With ordered_mode = 0, exc_invalid is raised only when an operand is a signalling NaN (top fraction bit 0). With ordered_mode = 1, it is raised for any NaN.
- R7: exc_denorm is raised when either operand has a zero exponent and a nonzero fraction. Denormals are compared exactly, without flushing to zero.
- R8: A mask bit of 1 masks its condition. If a raised condition is unmasked, exc_trap is 1 and zf, pf and cf keep their previous values. Otherwise the flags update.
- R9: With dbl_sel = 0 only bits [31:0] of each operand are used. With dbl_sel = 1 only bits [63:0] are used. All higher bits have no effect.
- R10: out_valid and the new result appear one clock after in_valid. When in_valid is low, out_valid is 0 on the next cycle and the flags do not change.
- R11: A synchronous active-low reset clears all flags, out_valid and the three exception outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Start a compare this cycle |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| ordered_mode | input | 1 | 1 = any NaN is invalid, 0 = only signalling NaN is invalid |
| mask_invalid | input | 1 | 1 masks the invalid-operation trap |
| mask_denorm | input | 1 | 1 masks the denormal trap |
| opa | input | 128 | Operand A bus |
| opb | input | 128 | Operand B bus |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always 0 |
| sf | output | 1 | Sign flag, always 0 |
| af | output | 1 | Auxiliary flag, always 0 |
| exc_invalid | output | 1 | Invalid-operation condition raised by this compare |
| exc_denorm | output | 1 | Denormal-operand condition raised by this compare |
| exc_trap | output | 1 | An unmasked condition was raised; flags were held |

## Verification
Some behaviours are checked by assertions on every cycle:
- the flag code only ever takes one of the four legal values;
- exactly one outcome is decoded per compare;
- flags hold across idle cycles and across trapped compares;
- a NaN operand leads to the unordered code;
- a signalling NaN always raises invalid.

Other behaviours can only be shown by the bench's scenarios:
- the ordering of particular values: signed zeros, infinities, adjacent denormals;
- the split between the two NaN modes;
- the insensitivity to bits above the selected precision;
- the one-cycle timing;
- the effect of a mid-run reset.

// File: rtl/fpcmp_pkg.sv
// Shared types for the scalar compare flag unit.
// Assumes magnitudes of both precisions fit in MAG_W bits (double: 63).
package fpcmp_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
    localparam int DP_W      = DP_EXP_W + DP_FRAC_W + 1;
    localparam int MAG_W     = DP_W - 1;

    // Decoded view of one operand.
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic             is_denorm;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef enum logic [1:0] {
        OUT_GT = 2'd0,
        OUT_LT = 2'd1,
        OUT_EQ = 2'd2,
        OUT_UN = 2'd3
    } outcome_e;

    // Six-bit status word held by the flag register.
    typedef struct packed {
        logic of;
        logic sf;
        logic af;
        logic zf;
        logic pf;
        logic cf;
    } flags_t;

    // Map an outcome to its status word; side bits always cleared.
    function automatic flags_t encode_flags(outcome_e o);
        flags_t f;
        f = '0;
        case (o)
            OUT_GT:  {f.zf, f.pf, f.cf} = 3'b000;
            OUT_LT:  {f.zf, f.pf, f.cf} = 3'b001;
            OUT_EQ:  {f.zf, f.pf, f.cf} = 3'b100;
            default: {f.zf, f.pf, f.cf} = 3'b111;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
// Decodes one IEEE-754 value of width EXP_W+FRAC_W+1 into class bits and an
// unsigned magnitude (exponent and fraction), zero-extended to MAG_W.
// Assumes EXP_W+FRAC_W <= MAG_W.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int VAL_W = EXP_W + FRAC_W + 1
) (
    input  logic [VAL_W-1:0] value,
    output fp_class_t        cls
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_all_ones;
    logic              exp_all_zero;
    logic              frac_nonzero;

    // Split fields and reduce them.
    always_comb begin
        exp_f        = value[VAL_W-2:FRAC_W];
        frac_f       = value[FRAC_W-1:0];
        exp_all_ones = &exp_f;
        exp_all_zero = ~|exp_f;
        frac_nonzero = |frac_f;
    end

    // Form the class record.
    always_comb begin
        cls.sign      = value[VAL_W-1];
        cls.is_nan    = exp_all_ones & frac_nonzero;
        cls.is_snan   = exp_all_ones & frac_nonzero & ~frac_f[FRAC_W-1];
        cls.is_zero   = exp_all_zero & ~frac_nonzero;
        cls.is_denorm = exp_all_zero & frac_nonzero;
        cls.mag       = MAG_W'(value[VAL_W-2:0]);
    end

endmodule

// File: rtl/fpcmp_order.sv
// Orders two classified operands into one of four outcomes.
// Assumes NaN detection is already in the class records; zeros of either sign
// are equal; denormals are compared by raw magnitude (no flushing).
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    output outcome_e  outcome
);

    logic unord, both_zero, mag_eq, a_mag_gt, a_above;
    logic is_gt, is_lt, is_eq;

    // Raw relations between magnitudes and signs.
    always_comb begin
        unord     = cls_a.is_nan | cls_b.is_nan;
        both_zero = cls_a.is_zero & cls_b.is_zero;
        mag_eq    = (cls_a.mag == cls_b.mag);
        a_mag_gt  = (cls_a.mag > cls_b.mag);
        if (cls_a.sign != cls_b.sign)
            a_above = ~cls_a.sign;
        else if (!cls_a.sign)
            a_above = a_mag_gt;
        else
            a_above = ~a_mag_gt & ~mag_eq;
    end

    // Resolve into exclusive outcome lines.
    always_comb begin
        is_eq = ~unord & (both_zero | ((cls_a.sign == cls_b.sign) & mag_eq));
        is_gt = ~unord & ~is_eq & a_above;
        is_lt = ~unord & ~is_eq & ~a_above;
    end

    // Encode the outcome lines.
    always_comb begin
        if (unord)      outcome = OUT_UN;
        else if (is_eq) outcome = OUT_EQ;
        else if (is_gt) outcome = OUT_GT;
        else            outcome = OUT_LT;
    end

    // Exactly one of the four outcome lines is active (R1..R4).
    assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_gt, is_lt, is_eq, unord}) == 1);

endmodule

// File: rtl/fpcmp_except.sv
// Detects invalid and denormal conditions and decides whether they trap.
// Assumes mask bits use 1 = masked.
module fpcmp_except
    import fpcmp_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  logic      ordered_mode,
    input  logic      mask_invalid,
    input  logic      mask_denorm,
    output logic      raise_inv,
    output logic      raise_den,
    output logic      trap
);

    logic any_nan, any_snan;

    // Select the invalid rule for the mode and gate with the masks.
    always_comb begin
        any_nan   = cls_a.is_nan | cls_b.is_nan;
        any_snan  = cls_a.is_snan | cls_b.is_snan;
        raise_inv = ordered_mode ? any_nan : any_snan;
        raise_den = cls_a.is_denorm | cls_b.is_denorm;
        trap      = (raise_inv & ~mask_invalid) | (raise_den & ~mask_denorm);
    end

endmodule

// File: rtl/fpcmp_flagreg.sv
// Holds the status word and the per-compare exception outputs.
// Assumes in_valid is a one-cycle strobe; the status word updates only on an
// untrapped compare and otherwise holds.
module fpcmp_flagreg
    import fpcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  outcome_e outcome,
    input  logic     raise_inv,
    input  logic     raise_den,
    input  logic     trap,
    output flags_t   flags,
    output logic     out_valid,
    output logic     exc_invalid,
    output logic     exc_denorm,
    output logic     exc_trap
);

    // Register the strobe, the exception report and the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags       <= '0;
            out_valid   <= 1'b0;
            exc_invalid <= 1'b0;
            exc_denorm  <= 1'b0;
            exc_trap    <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            exc_invalid <= in_valid & raise_inv;
            exc_denorm  <= in_valid & raise_den;
            exc_trap    <= in_valid & trap;
            if (in_valid && !trap)
                flags <= encode_flags(outcome);
        end
    end

    // A trapped compare leaves the flags as they were (R8).
    assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && exc_trap) |-> (flags == $past(flags)));

    // No strobe: no result and unchanged flags next cycle (R10).
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(flags)));

    // Only the four legal codes ever appear (R2).
    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({flags.zf, flags.pf, flags.cf} == 3'b000) || ({flags.zf, flags.pf, flags.cf} == 3'b001) ||
        ({flags.zf, flags.pf, flags.cf} == 3'b100) || ({flags.zf, flags.pf, flags.cf} == 3'b111));

endmodule

// File: rtl/fp_cmp_flags.sv
// Top of the scalar compare flag unit: classifies both operands in each
// precision, selects one precision, orders, detects exceptions, registers.
// Assumes operands are right-aligned on OPND_W-bit buses.
module fp_cmp_flags
    import fpcmp_pkg::*;
#(
    parameter int OPND_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic              ordered_mode,
    input  logic              mask_invalid,
    input  logic              mask_denorm,
    input  logic [OPND_W-1:0] opa,
    input  logic [OPND_W-1:0] opb,
    output logic              out_valid,
    output logic              zf,
    output logic              pf,
    output logic              cf,
    output logic              of,
    output logic              sf,
    output logic              af,
    output logic              exc_invalid,
    output logic              exc_denorm,
    output logic              exc_trap
);

    localparam int N_OPND = 2;

    logic [OPND_W-1:0] opnd    [N_OPND];
    fp_class_t         cls_sp  [N_OPND];
    fp_class_t         cls_dp  [N_OPND];
    fp_class_t         cls_sel [N_OPND];
    outcome_e          outcome;
    logic              raise_inv, raise_den, trap;
    flags_t            flags;
    logic              unused_hi_bits;

    assign opnd[0] = opa;
    assign opnd[1] = opb;
    assign unused_hi_bits = ^{opa[OPND_W-1:DP_W], opb[OPND_W-1:DP_W]};

    // One classifier pair per operand, then a precision mux.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .value (opnd[g][SP_W-1:0]),
            .cls   (cls_sp[g])
        );
        fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
            .value (opnd[g][DP_W-1:0]),
            .cls   (cls_dp[g])
        );
        assign cls_sel[g] = dbl_sel ? cls_dp[g] : cls_sp[g];
    end

    fpcmp_order u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls_a   (cls_sel[0]),
        .cls_b   (cls_sel[1]),
        .outcome (outcome)
    );

    fpcmp_except u_except (
        .cls_a        (cls_sel[0]),
        .cls_b        (cls_sel[1]),
        .ordered_mode (ordered_mode),
        .mask_invalid (mask_invalid),
        .mask_denorm  (mask_denorm),
        .raise_inv    (raise_inv),
        .raise_den    (raise_den),
        .trap         (trap)
    );

    fpcmp_flagreg u_flagreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .outcome     (outcome),
        .raise_inv   (raise_inv),
        .raise_den   (raise_den),
        .trap        (trap),
        .flags       (flags),
        .out_valid   (out_valid),
        .exc_invalid (exc_invalid),
        .exc_denorm  (exc_denorm),
        .exc_trap    (exc_trap)
    );

    // Break the status word out to the flag pins.
    always_comb begin
        zf = flags.zf;
        pf = flags.pf;
        cf = flags.cf;
        of = flags.of;
        sf = flags.sf;
        af = flags.af;
    end

    // A NaN input without a trap yields the unordered code (R1).
    assert_nan_unordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls_sel[0].is_nan || cls_sel[1].is_nan) && !trap)
            |=> ({zf, pf, cf} == 3'b111));

    // A signalling NaN is invalid in both modes (R6).
    assert_snan_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls_sel[0].is_snan || cls_sel[1].is_snan)) |=> exc_invalid);

endmodule

// File: tb/tb_fp_cmp_flags.sv
// Self-checking bench: vector table walk, then directed reset and timing tests.
module tb_fp_cmp_flags;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, dbl_sel = 1'b0, ordered_mode = 1'b0;
    logic         mask_invalid = 1'b1, mask_denorm = 1'b1;
    logic [127:0] opa = '0, opb = '0;
    logic         out_valid, zf, pf, cf, of, sf, af;
    logic         exc_invalid, exc_denorm, exc_trap;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fp_cmp_flags dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .ordered_mode(ordered_mode), .mask_invalid(mask_invalid),
        .mask_denorm(mask_denorm), .opa(opa), .opb(opb), .out_valid(out_valid),
        .zf(zf), .pf(pf), .cf(cf), .of(of), .sf(sf), .af(af),
        .exc_invalid(exc_invalid), .exc_denorm(exc_denorm), .exc_trap(exc_trap)
    );

    typedef struct packed {
        logic        dbl;
        logic        ord;
        logic        mi;
        logic        md;
        logic [63:0] a;
        logic [63:0] b;
        logic [2:0]  zpc;
        logic        inv;
        logic        den;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,64'h40000000,64'h3F800000,3'b000,1'b0,1'b0,4'd2},     // R2 2>1
        '{1'b0,1'b0,1'b1,1'b1,64'h3F800000,64'h40000000,3'b001,1'b0,1'b0,4'd3},     // R3 1<2
        '{1'b0,1'b0,1'b1,1'b1,64'hBF800000,64'h3F800000,3'b001,1'b0,1'b0,4'd3},     // R3 -1<1
        '{1'b0,1'b0,1'b1,1'b1,64'h00000000,64'h80000000,3'b100,1'b0,1'b0,4'd4},     // R4 +0==-0
        '{1'b0,1'b0,1'b1,1'b1,64'h7FC00000,64'h3F800000,3'b111,1'b0,1'b0,4'd1},     // R1 qnan relaxed
        '{1'b0,1'b0,1'b1,1'b1,64'h3F800000,64'h7F800001,3'b111,1'b1,1'b0,4'd6},     // R6 snan relaxed
        '{1'b0,1'b1,1'b1,1'b1,64'h7FC00000,64'h3F800000,3'b111,1'b1,1'b0,4'd6},     // R6 qnan strict
        '{1'b0,1'b0,1'b1,1'b1,64'h00000001,64'h00000002,3'b001,1'b0,1'b1,4'd7},     // R7 denorm order
        '{1'b1,1'b0,1'b1,1'b1,64'h4000000000000000,64'h3FF0000000000000,3'b000,1'b0,1'b0,4'd9}, // R9
        '{1'b1,1'b0,1'b1,1'b1,64'h3FF0000000000000,64'h4000000000000000,3'b001,1'b0,1'b0,4'd9}, // R9
        '{1'b1,1'b0,1'b1,1'b1,64'hC000000000000000,64'hFFF0000000000000,3'b000,1'b0,1'b0,4'd2}, // R2 -2>-inf
        '{1'b1,1'b0,1'b1,1'b1,64'h3FF0000000000000,64'h3FF0000000000000,3'b100,1'b0,1'b0,4'd4}, // R4
        '{1'b1,1'b0,1'b0,1'b1,64'h7FF0000000000001,64'h3FF0000000000000,3'b111,1'b1,1'b0,4'd8}, // R8 trap hold
        '{1'b1,1'b1,1'b0,1'b1,64'h7FF8000000000000,64'h3FF0000000000000,3'b111,1'b1,1'b0,4'd6}, // R6 strict trap
        '{1'b1,1'b0,1'b0,1'b1,64'h7FF8000000000000,64'h3FF0000000000000,3'b111,1'b0,1'b0,4'd6}, // R6 qnan no trap
        '{1'b0,1'b0,1'b1,1'b0,64'h00000001,64'h3F800000,3'b001,1'b0,1'b1,4'd7},     // R7 denorm trap
        '{1'b0,1'b0,1'b1,1'b1,64'h3F800000,64'h3F800000,3'b100,1'b0,1'b0,4'd9},     // R9 upper bits differ
        '{1'b1,1'b0,1'b1,1'b1,64'h0000000000000001,64'h0000000000000000,3'b000,1'b0,1'b1,4'd7}  // R7 no flush
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one compare at a negedge, sample at the following negedge.
    task automatic compare(input logic d, input logic o, input logic mi, input logic md,
                           input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid     = 1'b1;
        dbl_sel      = d;
        ordered_mode = o;
        mask_invalid = mi;
        mask_denorm  = md;
        opa = d ? {64'hFFF8_0000_DEAD_BEEF, a} : {64'hFFF8_0000_DEAD_BEEF, 32'h7FF80000, a[31:0]};
        opb = d ? {64'h0123_4567_89AB_CDEF, b} : {64'h0123_4567_89AB_CDEF, 32'h12345678, b[31:0]};
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    logic [2:0] exp_zpc;
    logic       exp_trap;

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check({zf, pf, cf, of, sf, af} == 6'b0, "R11", "flags after reset", {2'b0, zf, pf, cf, of, sf, af}, 8'h00);
        check({out_valid, exc_invalid, exc_denorm, exc_trap} == 4'b0, "R11", "strobe/exc after reset",
              {4'b0, out_valid, exc_invalid, exc_denorm, exc_trap}, 8'h00);

        exp_zpc = 3'b000;
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            compare(VEC[i].dbl, VEC[i].ord, VEC[i].mi, VEC[i].md, VEC[i].a, VEC[i].b);
            exp_trap = (VEC[i].inv & ~VEC[i].mi) | (VEC[i].den & ~VEC[i].md);
            if (!exp_trap) exp_zpc = VEC[i].zpc;
            check({zf, pf, cf} == exp_zpc, rq, $sformatf("vec %0d zpc", i), {5'b0, zf, pf, cf}, {5'b0, exp_zpc});
            check({exc_invalid, exc_denorm, exc_trap} == {VEC[i].inv, VEC[i].den, exp_trap}, rq,
                  $sformatf("vec %0d exc", i), {5'b0, exc_invalid, exc_denorm, exc_trap},
                  {5'b0, VEC[i].inv, VEC[i].den, exp_trap});
            // R5: side flags zero, R10: strobe present
            check({of, sf, af} == 3'b0 && out_valid, "R5", $sformatf("vec %0d side/valid", i),
                  {4'b0, out_valid, of, sf, af}, 8'h08);
        end

        // R10: latency and hold while idle
        compare(1'b1, 1'b0, 1'b1, 1'b1, 64'h3FF0000000000000, 64'h4000000000000000);
        check(out_valid && {zf, pf, cf} == 3'b001, "R10", "result one cycle after strobe",
              {4'b0, out_valid, zf, pf, cf}, 8'h09);
        opa = '0;
        opb = {64'h0, 64'h7FF8000000000000};
        @(negedge clk);
        check(!out_valid && {zf, pf, cf} == 3'b001, "R10", "idle keeps flags",
              {4'b0, out_valid, zf, pf, cf}, 8'h01);
        @(negedge clk);
        check(!out_valid && {zf, pf, cf} == 3'b001, "R10", "idle keeps flags 2",
              {4'b0, out_valid, zf, pf, cf}, 8'h01);

        // R9: double-precision sign bit at 63, single would see 0 vs 0
        compare(1'b1, 1'b0, 1'b1, 1'b1, 64'h8000000000000000, 64'h0000000000000000);
        check({zf, pf, cf} == 3'b100, "R9", "dp -0 == +0", {5'b0, zf, pf, cf}, 8'h04);

        // R6: relaxed quiet NaN with invalid unmasked does not trap
        compare(1'b0, 1'b0, 1'b0, 1'b0, 64'h3F800000, 64'h7FC00000);
        check({zf, pf, cf} == 3'b111 && !exc_trap && !exc_invalid, "R6", "relaxed qnan unmasked",
              {4'b0, exc_trap, zf, pf, cf}, 8'h07);

        // R11: mid-run reset clears the flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check({zf, pf, cf, out_valid, exc_invalid, exc_denorm, exc_trap} == 7'b0, "R11", "mid-run reset",
              {1'b0, zf, pf, cf, out_valid, exc_invalid, exc_denorm, exc_trap}, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule